// File: doc/BRIEF.md
# USB Endpoint Buffer Descriptor Engine

This block is the USB-engine side of an endpoint buffer scheme shared with a CPU. Every endpoint number has two four-byte descriptors, one for each direction. Both sides reach the descriptors through a small dual-port descriptor RAM that sits inside the block. The CPU side is a plain synchronous port. When the protocol layer accepts a token, the engine reads the descriptor, applies the per-endpoint configuration pins and the descriptor's own flags, and then does one of two things. It either answers at once with NAK or STALL, or it hands a buffer start address and a 10-bit byte count to the packet datapath.

While the datapath moves bytes, the engine supplies the current buffer address. After the datapath reports completion, the engine writes the actual count and the token PID back into the descriptor and gives ownership back to the CPU, unless the descriptor asks to stay owned.

Tokens, transfer grants, completions and results each travel on their own valid/ready stream. A sender raises valid and keeps it up, with its payload unchanged, until the cycle in which ready is high. Every stream may be held back for any number of cycles. The engine works on one token at a time and raises `tok_ready` only when it is idle. The configuration pins and `byte_stb` are plain level inputs.

Top module: `bd_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, `tok_ready` is 1 and `xfer_valid`, `done_ready` and `res_valid` are 0.
- R2: Descriptor byte k of endpoint e, direction d (d=1 for IN) is at RAM address {e,d,k[1:0]}. The bytes are: 0 status, 1 count bits 7:0, 2 address bits 7:0, 3 address bits 15:8. Count bits 9:8 are status bits 1:0. On a grant, `xfer_addr`, `xfer_cnt` and `xfer_in` carry these values, and `xfer_tog` carries status bit 6 (the expected DATA0/DATA1 value).
- R3: If the endpoint's enable pin for the token's direction is 0, the result is NAK (code 1) and the descriptor is not written.
- R4: Otherwise, if the ownership flag (status bit 7) is 0, the result is NAK and the descriptor is not written.
- R5: If `ep_stall` is set for the endpoint (this is checked before ownership), or if the endpoint is owned and status bit 2 is set, the result is STALL (code 2). The descriptor is not written.
- R6: On completion, the status byte becomes {keep, 0, token PID[3:0], count[9:8]} and byte 1 becomes count[7:0], where the count is `done_cnt`. Bytes 2 and 3 are left unchanged.
- R7: With keep (status bit 5) set, write-back leaves bit 7 at 1. With keep clear, write-back leaves bit 7 at 0.
- R8: For an OUT token with toggle checking on (status bit 3), a `done_tog` that differs from status bit 6 still gives the acknowledge code, but the descriptor is left untouched and stays owned.
- R9: `buf_addr` loads the base address when the grant is accepted. It then steps by one on each `byte_stb`, unless status bit 4 is set, in which case it holds the base address.
- R10: A granted transaction on an endpoint with `ep_nohs` set ends with code NONE (3). Otherwise it ends with ACK (code 0).
- R11: While `xfer_valid` or `res_valid` is up and ready is low, the signal stays up and its payload does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | CPU port access enable |
| cpu_we | input | 1 | CPU port write enable |
| cpu_addr | input | DESC_AW | CPU byte address into descriptor RAM |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after the access |
| ep_en_in | input | NUM_EP | Per-endpoint IN enable |
| ep_en_out | input | NUM_EP | Per-endpoint OUT/SETUP enable |
| ep_stall | input | NUM_EP | Per-endpoint forced stall |
| ep_nohs | input | NUM_EP | Per-endpoint handshake disable (isochronous) |
| tok_valid | input | 1 | Token stream valid |
| tok_ready | output | 1 | Token stream ready |
| tok_ep | input | EP_W | Token endpoint number |
| tok_in | input | 1 | Token direction, 1 = IN |
| tok_pid | input | 4 | Token PID |
| xfer_valid | output | 1 | Grant stream valid |
| xfer_ready | input | 1 | Grant stream ready |
| xfer_addr | output | 16 | Buffer start address |
| xfer_cnt | output | 10 | Bytes to send / bytes allowed |
| xfer_in | output | 1 | Granted direction |
| xfer_tog | output | 1 | Expected data toggle |
| byte_stb | input | 1 | One buffer byte moved this cycle |
| buf_addr | output | 16 | Current buffer byte address |
| done_valid | input | 1 | Completion stream valid |
| done_ready | output | 1 | Completion stream ready |
| done_cnt | input | 10 | Actual byte count |
| done_tog | input | 1 | Data toggle seen on OUT data |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 NONE |

## Verification
Some properties are checked on every cycle: the engine stays quiet while idle, rejected tokens never write the descriptor RAM, the write-back status byte carries the accepted token's PID, the buffer address holds between byte strobes, and stream payloads stay stable while stalled. Other behaviour shows only in the bench's scenarios, where descriptors are read back through the CPU port and compared with a reference model. That covers the decision order among disabled, forced-stall, unowned and stall-bit descriptors, the keep-enable ownership result, a toggle mismatch followed by a matching retry, and the held address when increment is disabled.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [1:0] {
    RES_ACK   = 2'd0,
    RES_NAK   = 2'd1,
    RES_STALL = 2'd2,
    RES_NONE  = 2'd3
  } res_code_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECIDE, S_XFER, S_RUN, S_WB, S_RESP
  } eng_state_e;

  // status byte bit positions (CPU-written layout)
  localparam int ST_BSTALL = 2;
  localparam int ST_DTSEN  = 3;
  localparam int ST_INCDIS = 4;
  localparam int ST_KEEP   = 5;
  localparam int ST_DTS    = 6;
  localparam int ST_OWN    = 7;

  typedef struct packed {
    logic [7:0] adr_hi;
    logic [7:0] adr_lo;
    logic [7:0] cnt_lo;
    logic [7:0] stat;
  } desc_t;

  // engine-written status layout
  function automatic logic [7:0] wb_status(input logic keep, input logic [3:0] pid,
                                           input logic [9:0] cnt);
    return {keep, 1'b0, pid, cnt[9:8]};
  endfunction
endpackage

// File: rtl/bd_dpram.sv
module bd_dpram #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [0:DEPTH-1];
  logic a_wr, b_wr;

  assign a_wr = a_en && a_we;
  // CPU port wins a same-address write collision
  assign b_wr = b_en && b_we && !(a_wr && (a_addr == b_addr));

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_en) a_rdata <= mem[a_addr];
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/bd_policy.sv
module bd_policy
  import bd_pkg::*;
(
  input  logic [7:0] stat,
  input  logic       ep_en,
  input  logic       ep_stall,
  input  logic       ep_nohs,
  output logic       grant,
  output res_code_e  code
);
  always_comb begin
    grant = 1'b0;
    code  = RES_NAK;
    if (!ep_en)                 code = RES_NAK;
    else if (ep_stall)          code = RES_STALL;
    else if (!stat[ST_OWN])     code = RES_NAK;
    else if (stat[ST_BSTALL])   code = RES_STALL;
    else begin
      grant = 1'b1;
      code  = ep_nohs ? RES_NONE : RES_ACK;
    end
  end
endmodule

// File: rtl/bd_addr_gen.sv
module bd_addr_gen #(
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] base,
  input  logic          step,
  input  logic          hold,
  output logic [BW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)              addr <= '0;
    else if (load)           addr <= base;
    else if (step && !hold)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/bd_engine.sv
module bd_engine
  import bd_pkg::*;
#(
  parameter int NUM_EP  = 16,
  localparam int EP_W    = $clog2(NUM_EP),
  localparam int DESC_AW = EP_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_en,
  input  logic               cpu_we,
  input  logic [DESC_AW-1:0] cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic [NUM_EP-1:0]  ep_en_in,
  input  logic [NUM_EP-1:0]  ep_en_out,
  input  logic [NUM_EP-1:0]  ep_stall,
  input  logic [NUM_EP-1:0]  ep_nohs,
  input  logic               tok_valid,
  output logic               tok_ready,
  input  logic [EP_W-1:0]    tok_ep,
  input  logic               tok_in,
  input  logic [3:0]         tok_pid,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [15:0]        xfer_addr,
  output logic [9:0]         xfer_cnt,
  output logic               xfer_in,
  output logic               xfer_tog,
  input  logic               byte_stb,
  output logic [15:0]        buf_addr,
  input  logic               done_valid,
  output logic               done_ready,
  input  logic [9:0]         done_cnt,
  input  logic               done_tog,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [1:0]         res_code
);
  eng_state_e       state;
  logic [2:0]       fcnt;
  logic [EP_W-1:0]  ep_q;
  logic             in_q;
  logic [3:0]       pid_q;
  desc_t            desc_q;
  res_code_e        code_q;
  logic [9:0]       cnt_q;
  logic             wbi;

  logic             eng_en, eng_we;
  logic [DESC_AW-1:0] eng_addr;
  logic [7:0]       eng_wdata, eng_rdata;

  logic             pol_en, pol_grant;
  res_code_e        pol_code;
  logic             tog_bad;

  bd_dpram #(.AW(DESC_AW)) u_ram (
    .clk(clk),
    .a_en(cpu_en), .a_we(cpu_we), .a_addr(cpu_addr), .a_wdata(cpu_wdata), .a_rdata(cpu_rdata),
    .b_en(eng_en), .b_we(eng_we), .b_addr(eng_addr), .b_wdata(eng_wdata), .b_rdata(eng_rdata)
  );

  assign pol_en = in_q ? ep_en_in[ep_q] : ep_en_out[ep_q];

  bd_policy u_pol (
    .stat(desc_q.stat), .ep_en(pol_en), .ep_stall(ep_stall[ep_q]),
    .ep_nohs(ep_nohs[ep_q]), .grant(pol_grant), .code(pol_code)
  );

  bd_addr_gen #(.BW(16)) u_agen (
    .clk(clk), .rst_n(rst_n),
    .load(state == S_XFER && xfer_ready),
    .base({desc_q.adr_hi, desc_q.adr_lo}),
    .step(state == S_RUN && byte_stb),
    .hold(desc_q.stat[ST_INCDIS]),
    .addr(buf_addr)
  );

  // descriptor RAM engine port
  always_comb begin
    eng_en    = 1'b0;
    eng_we    = 1'b0;
    eng_addr  = {ep_q, in_q, 2'b00};
    eng_wdata = '0;
    if (state == S_FETCH && fcnt < 3'd4) begin
      eng_en   = 1'b1;
      eng_addr = {ep_q, in_q, fcnt[1:0]};
    end else if (state == S_WB) begin
      eng_en    = 1'b1;
      eng_we    = 1'b1;
      eng_addr  = {ep_q, in_q, 1'b0, wbi};
      eng_wdata = wbi ? cnt_q[7:0]
                      : wb_status(desc_q.stat[ST_KEEP], pid_q, cnt_q);
    end
  end

  assign tog_bad = !in_q && desc_q.stat[ST_DTSEN] && (done_tog != desc_q.stat[ST_DTS]);

  assign tok_ready  = (state == S_IDLE);
  assign xfer_valid = (state == S_XFER);
  assign done_ready = (state == S_RUN);
  assign res_valid  = (state == S_RESP);
  assign res_code   = code_q;
  assign xfer_addr  = {desc_q.adr_hi, desc_q.adr_lo};
  assign xfer_cnt   = {desc_q.stat[1:0], desc_q.cnt_lo};
  assign xfer_in    = in_q;
  assign xfer_tog   = desc_q.stat[ST_DTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fcnt   <= '0;
      ep_q   <= '0;
      in_q   <= 1'b0;
      pid_q  <= '0;
      desc_q <= '0;
      code_q <= RES_ACK;
      cnt_q  <= '0;
      wbi    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (tok_valid) begin
          ep_q  <= tok_ep;
          in_q  <= tok_in;
          pid_q <= tok_pid;
          fcnt  <= '0;
          state <= S_FETCH;
        end
        S_FETCH: begin
          case (fcnt)
            3'd1: desc_q.stat   <= eng_rdata;
            3'd2: desc_q.cnt_lo <= eng_rdata;
            3'd3: desc_q.adr_lo <= eng_rdata;
            3'd4: desc_q.adr_hi <= eng_rdata;
            default: ;
          endcase
          fcnt <= fcnt + 3'd1;
          if (fcnt == 3'd4) state <= S_DECIDE;
        end
        S_DECIDE: begin
          code_q <= pol_code;
          state  <= pol_grant ? S_XFER : S_RESP;
        end
        S_XFER: if (xfer_ready) state <= S_RUN;
        S_RUN: if (done_valid) begin
          cnt_q <= done_cnt;
          wbi   <= 1'b0;
          state <= tog_bad ? S_RESP : S_WB;
        end
        S_WB: begin
          wbi <= 1'b1;
          if (wbi) state <= S_RESP;
        end
        S_RESP: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bd_engine_chk.sv
module bd_engine_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok_valid,
  input logic          tok_ready,
  input logic [3:0]    tok_pid,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [15:0]   xfer_addr,
  input logic [9:0]    xfer_cnt,
  input logic          byte_stb,
  input logic [15:0]   buf_addr,
  input logic          done_valid,
  input logic          done_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [1:0]    res_code,
  input logic          eng_we,
  input logic [AW-1:0] eng_addr,
  input logic [7:0]    eng_wdata
);
  logic       wrote, running;
  logic [3:0] pid_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrote   <= 1'b0;
      running <= 1'b0;
      pid_c   <= '0;
    end else begin
      if (tok_valid && tok_ready) begin
        wrote <= 1'b0;
        pid_c <= tok_pid;
      end else if (eng_we) wrote <= 1'b1;
      if (xfer_valid && xfer_ready)      running <= 1'b1;
      else if (done_valid && done_ready) running <= 1'b0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tok_ready |-> (!xfer_valid && !res_valid && !done_ready));

  // rejects (disabled R3, unowned R4, stalled R5) leave the descriptor alone
  assert_reject_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_code == 2'd1 || res_code == 2'd2)) |-> !wrote);

  assert_wb_pid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && eng_addr[1:0] == 2'b00) |-> (eng_wdata[5:2] == pid_c && !eng_wdata[6]));

  assert_bufaddr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !byte_stb) |=> $stable(buf_addr));

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code)));

  assert_xfer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_cnt)));
endmodule

bind bd_engine bd_engine_chk #(.AW(DESC_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_pid(tok_pid),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_cnt(xfer_cnt),
  .byte_stb(byte_stb), .buf_addr(buf_addr), .done_valid(done_valid), .done_ready(done_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
  .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata)
);

// File: tb/sim_bd_engine.sv
module sim_bd_engine;
  localparam int NEP = 16;
  localparam int EW  = 4;
  localparam int AW  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cpu_en = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic [NEP-1:0] ep_en_in = '1, ep_en_out = '1, ep_stall = '0, ep_nohs = '0;
  logic tok_valid = 0, tok_ready, tok_in = 0;
  logic [EW-1:0] tok_ep = '0;
  logic [3:0] tok_pid = '0;
  logic xfer_valid, xfer_ready = 0, xfer_in, xfer_tog;
  logic [15:0] xfer_addr, buf_addr;
  logic [9:0] xfer_cnt;
  logic byte_stb = 0;
  logic done_valid = 0, done_ready, done_tog = 0;
  logic [9:0] done_cnt = '0;
  logic res_valid, res_ready = 0;
  logic [1:0] res_code;

  bd_engine #(.NUM_EP(NEP)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] mdl [0:(1<<AW)-1];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input int a, input logic [7:0] d);
    @(negedge clk); cpu_en = 1; cpu_we = 1; cpu_addr = a[AW-1:0]; cpu_wdata = d;
    @(negedge clk); cpu_en = 0; cpu_we = 0;
    mdl[a] = d;
  endtask

  task automatic cpu_rd(input int a, output logic [7:0] d);
    @(negedge clk); cpu_en = 1; cpu_we = 0; cpu_addr = a[AW-1:0];
    @(negedge clk); cpu_en = 0; d = cpu_rdata;
  endtask

  task automatic set_desc(input int ep, input bit din, input logic [7:0] st,
                          input logic [7:0] cl, input logic [15:0] adr);
    int b = ep * 8 + (din ? 4 : 0);
    cpu_wr(b, st); cpu_wr(b + 1, cl); cpu_wr(b + 2, adr[7:0]); cpu_wr(b + 3, adr[15:8]);
  endtask

  task automatic verify_desc(input int ep, input bit din, input string tag);
    int b = ep * 8 + (din ? 4 : 0);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      cpu_rd(b + k, d);
      chk(d == mdl[b + k], tag, d, mdl[b + k]);
    end
  endtask

  // reference model of one token, from the requirements
  task automatic run_token(input int ep, input bit din, input logic [3:0] pid, input int nbytes,
                           input logic [9:0] dcnt, input bit dtog, input string tag);
    int b = ep * 8 + (din ? 4 : 0);
    logic [7:0] st = mdl[b];
    bit en = din ? ep_en_in[ep] : ep_en_out[ep];
    int exp_code;
    bit grant = 0;
    int wait_n = 0;
    if (!en) exp_code = 1;
    else if (ep_stall[ep]) exp_code = 2;
    else if (!st[7]) exp_code = 1;
    else if (st[2]) exp_code = 2;
    else begin grant = 1; exp_code = ep_nohs[ep] ? 3 : 0; end

    @(negedge clk);
    chk(tok_ready == 1'b1, {tag, " R1 idle ready"}, tok_ready, 1);
    tok_valid = 1; tok_ep = ep[EW-1:0]; tok_in = din; tok_pid = pid;
    @(negedge clk); tok_valid = 0;
    while (!xfer_valid && !res_valid && wait_n < 50) begin @(negedge clk); wait_n++; end

    if (grant) begin
      logic [15:0] base = {mdl[b + 3], mdl[b + 2]};
      chk(xfer_valid, {tag, " R2 grant"}, xfer_valid, 1);
      chk(xfer_addr == base, {tag, " R2 addr"}, xfer_addr, base);
      chk(xfer_cnt == {st[1:0], mdl[b + 1]}, {tag, " R2 count"}, xfer_cnt, {st[1:0], mdl[b + 1]});
      chk(xfer_in == din && xfer_tog == st[6], {tag, " R2 dir/tog"}, {xfer_in, xfer_tog}, {din, st[6]});
      @(negedge clk);
      chk(xfer_valid && xfer_addr == base, {tag, " R11 grant held"}, xfer_valid, 1);
      xfer_ready = 1;
      @(negedge clk); xfer_ready = 0;
      for (int k = 0; k <= nbytes; k++) begin
        int ea = base + (st[4] ? 0 : k);
        chk(buf_addr == ea[15:0], {tag, " R9 buf_addr"}, buf_addr, ea);
        if (k < nbytes) begin
          byte_stb = 1; @(negedge clk); byte_stb = 0;
          @(negedge clk);
        end
      end
      chk(done_ready, {tag, " R1 done_ready"}, done_ready, 1);
      done_valid = 1; done_cnt = dcnt; done_tog = dtog;
      @(negedge clk); done_valid = 0;
      if (!(!din && st[3] && dtog != st[6])) begin
        mdl[b] = {st[5], 1'b0, pid, dcnt[9:8]};
        mdl[b + 1] = dcnt[7:0];
      end
      wait_n = 0;
      while (!res_valid && wait_n < 50) begin @(negedge clk); wait_n++; end
    end else begin
      chk(!xfer_valid, {tag, " R3/R4/R5 no grant"}, xfer_valid, 0);
    end

    chk(res_valid && res_code == exp_code[1:0], {tag, " R10 result code"}, res_code, exp_code);
    @(negedge clk);
    chk(res_valid && res_code == exp_code[1:0], {tag, " R11 result held"}, res_code, exp_code);
    res_ready = 1;
    @(negedge clk); res_ready = 0;
    chk(tok_ready && !res_valid, {tag, " R1 back to idle"}, tok_ready, 1);
    verify_desc(ep, din, {tag, " R6/R7 descriptor"});
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(tok_ready && !xfer_valid && !res_valid && !done_ready, "R1 reset state", tok_ready, 1);
    rst_n = 1;
    for (int i = 0; i < (1 << AW); i++) cpu_wr(i, 8'h00);

    // R2 R6 R7: IN, count high bits 01, no keep -> status 0x24
    set_desc(1, 1, 8'h81, 8'h23, 16'h4000);
    run_token(1, 1, 4'b1001, 3, 10'd3, 0, "IN ep1");
    chk(mdl[12] == 8'h24, "R6 IN status value", mdl[12], 8'h24);

    // R7 R8 R9: OUT keep, toggle check, no increment, large count
    set_desc(2, 0, 8'hF8, 8'h40, 16'h1234);
    run_token(2, 0, 4'b0001, 4, 10'h2A5, 1, "OUT ep2 keep");
    chk(mdl[16] == 8'h86, "R7 keep leaves owned", mdl[16], 8'h86);

    // R8 mismatch, then a matching retry
    set_desc(3, 0, 8'hC8, 8'h10, 16'h2000);
    run_token(3, 0, 4'b0001, 2, 10'd2, 0, "OUT ep3 R8 mismatch");
    run_token(3, 0, 4'b0001, 2, 10'd2, 1, "OUT ep3 R8 retry");

    // R4 not owned
    set_desc(4, 1, 8'h00, 8'h08, 16'h3000);
    run_token(4, 1, 4'b1001, 0, 10'd0, 0, "IN ep4 R4 unowned");

    // R5 stall bit
    set_desc(5, 0, 8'h84, 8'h08, 16'h3100);
    run_token(5, 0, 4'b0001, 0, 10'd0, 0, "OUT ep5 R5 stall bit");

    // R5 stall pin on unowned descriptor
    set_desc(6, 0, 8'h00, 8'h08, 16'h3200);
    ep_stall[6] = 1;
    run_token(6, 0, 4'b0001, 0, 10'd0, 0, "OUT ep6 R5 stall pin");
    ep_stall[6] = 0;

    // R3 disabled direction
    set_desc(7, 0, 8'h80, 8'h08, 16'h3300);
    ep_en_out[7] = 0;
    run_token(7, 0, 4'b0001, 0, 10'd0, 0, "OUT ep7 R3 disabled");
    ep_en_out[7] = 1;

    // R10 no-handshake endpoint
    set_desc(8, 1, 8'h80, 8'h20, 16'h5000);
    ep_nohs[8] = 1;
    run_token(8, 1, 4'b1001, 5, 10'd32, 0, "IN ep8 R10 nohs");

    // control endpoint SETUP
    set_desc(0, 0, 8'h80, 8'h08, 16'h0100);
    run_token(0, 0, 4'b1101, 8, 10'd8, 0, "SETUP ep0");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule